// File: doc/BRIEF.md
# Approximate Base-2 Logarithm Converter

This block turns an unsigned integer into a fixed-point approximation of its base-2 logarithm. The integer part, called the characteristic, is the position of the highest set bit of the operand. The fractional part is the operand's bits that sit below that leading one, moved up so that they start at the top of a fraction field as wide as the operand. This is the linear, table-free approximation used ahead of log-domain multipliers and dividers, where products become sums of characteristics and fractions.

One operand is accepted per clock when `in_valid` is high. The characteristic is found first by a leading-one detector. A logarithmic barrel shifter then uses that characteristic to normalise the operand. The result is registered, so it appears one clock after the operand. An all-zero operand has no logarithm. It is reported through a separate flag, and the characteristic and fraction are then both zero. The operand width and the style of leading-one detector are parameters.

Top module: `log2_approx`

## Requirements
- R1: For a non-zero operand, `out_char` equals the bit index of the most significant 1 in the operand (index 0 is the LSB).
- R2: For a non-zero operand, `out_frac` holds the operand bits below the leading one, in their original order, placed so that the bit just below the leading one lands in `out_frac[DATA_W-1]`, with zeros filling the low end; an operand of 1 gives an all-zero fraction.
- R3: An all-zero operand sets `out_zero` to 1 and gives `out_char` = 0 and `out_frac` = 0.
- R4: A non-zero operand gives `out_zero` = 0.
- R5: `out_valid` is high in exactly the clock after a clock in which `in_valid` was high, and low otherwise.
- R6: While `in_valid` is low, `out_char`, `out_frac` and `out_zero` keep their last values, whatever `in_data` does.
- R7: While reset is asserted, `out_valid`, `out_char`, `out_frac` and `out_zero` are all 0.
- R8: With DATA_W = 16, the operand 16'h6735 gives `out_char` = 14 and `out_frac` = 16'h9CD4.
- R9: The results of R1 to R4 hold for an operand width that is not a power of two and for either leading-one detector style (priority scan or halving tree).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | DATA_W | Unsigned operand |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_char | output | CHAR_W | Characteristic (leading-one index) |
| out_frac | output | DATA_W | Left-aligned fraction |
| out_zero | output | 1 | Operand was zero |

## Verification
The bench builds two copies side by side. One has the default 16-bit width with the halving-tree detector. The other is 5 bits wide with the priority-scan detector. The 16-bit copy covers the worked example, the extreme operands 1, 16'h8000 and 16'hFFFF, every single-bit operand and a pseudo-random spread. The 5-bit copy's width falls short of a power of two, so its tree would need padding and its shift amount does not fill the full range of the shift-amount field. Its operand space is small enough that all 32 values are applied, with idle gaps between them to exercise the hold behaviour.

// File: rtl/lg2c_pkg.sv
package lg2c_pkg;

   typedef enum logic {
      LOD_SCAN = 1'b0,
      LOD_TREE = 1'b1
   } lod_style_e;

   function automatic int char_width(input int width);
      int w;
      w = $clog2(width);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/lg2c_lead_one.sv
module lg2c_lead_one
   import lg2c_pkg::*;
#(
   parameter int         WIDTH  = 16,
   parameter int         IDX_W  = 4,
   parameter lod_style_e STYLE  = LOD_TREE
) (
   input  logic [WIDTH-1:0] vec,
   output logic [IDX_W-1:0] idx,
   output logic             any
);

   localparam int PADDED = 1 << IDX_W;

   assign any = |vec;

   if (PADDED < WIDTH) begin : g_bad_idx
      $error("lg2c_lead_one: IDX_W too small for WIDTH");
   end

   if (STYLE == LOD_SCAN) begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = 0; i < WIDTH; i++) begin
            if (vec[i]) idx = IDX_W'(i);
         end
      end
   end else begin : g_tree
      logic [PADDED-1:0] lvl [0:IDX_W];
      logic [IDX_W-1:0]  hit;

      assign lvl[0] = PADDED'(vec);

      for (genvar s = 0; s < IDX_W; s++) begin : g_stage
         localparam int HALF = 1 << (IDX_W - 1 - s);
         assign hit[s]      = |lvl[s][2*HALF-1:HALF];
         assign lvl[s+1]    = hit[s] ? (lvl[s] >> HALF) : lvl[s];
         assign idx[IDX_W-1-s] = hit[s];
      end
   end

endmodule

// File: rtl/lg2c_norm_shift.sv
module lg2c_norm_shift #(
   parameter int WIDTH = 16,
   parameter int AMT_W = 4
) (
   input  logic [WIDTH-1:0] din,
   input  logic [AMT_W-1:0] amt,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] st [0:AMT_W];

   assign st[0] = din;

   for (genvar i = 0; i < AMT_W; i++) begin : g_stage
      localparam int STEP = 1 << i;
      if (STEP >= WIDTH) begin : g_flush
         assign st[i+1] = amt[i] ? '0 : st[i];
      end else begin : g_shift
         assign st[i+1] = amt[i] ? (st[i] << STEP) : st[i];
      end
   end

   assign dout = st[AMT_W];

endmodule

// File: rtl/log2_approx.sv
module log2_approx
   import lg2c_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter lod_style_e LOD_STYLE = LOD_TREE,
   parameter int         CHAR_W    = lg2c_pkg::char_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char,
   output logic [DATA_W-1:0] out_frac,
   output logic              out_zero
);

   localparam logic [CHAR_W-1:0] TOP_IDX = CHAR_W'(DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("log2_approx: DATA_W must be at least 2");
   end
   if (CHAR_W != lg2c_pkg::char_width(DATA_W)) begin : g_bad_char
      $error("log2_approx: CHAR_W must not be overridden");
   end

   logic [CHAR_W-1:0] lod_idx;
   logic              lod_any;
   logic [CHAR_W-1:0] shift_amt;
   logic [DATA_W-1:0] norm_word;
   logic [DATA_W-1:0] frac_next;

   lg2c_lead_one #(
      .WIDTH (DATA_W),
      .IDX_W (CHAR_W),
      .STYLE (LOD_STYLE)
   ) lod_i (
      .vec (in_data),
      .idx (lod_idx),
      .any (lod_any)
   );

   assign shift_amt = TOP_IDX - lod_idx;

   lg2c_norm_shift #(
      .WIDTH (DATA_W),
      .AMT_W (CHAR_W)
   ) shf_i (
      .din  (in_data),
      .amt  (shift_amt),
      .dout (norm_word)
   );

   assign frac_next = {norm_word[DATA_W-2:0], 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_char  <= '0;
         out_frac  <= '0;
         out_zero  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_char <= lod_any ? lod_idx : '0;
            out_frac <= lod_any ? frac_next : '0;
            out_zero <= ~lod_any;
         end
      end
   end

   // R1: detector index points at the top set bit
   a_r1_lead_index : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data != '0) |-> ((in_data >> lod_idx) == DATA_W'(1)));

   // R2: normalised word carries the leading one in its top bit
   a_r2_norm_top : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_data != '0) |-> norm_word[DATA_W-1]);

   // R3: zero flag forces empty characteristic and fraction
   a_r3_zero_clear : assert property (@(posedge clk) disable iff (!rst_n)
      out_zero |-> (out_char == '0 && out_frac == '0));

   // R4: zero flag tracks the captured operand
   a_r4_zero_flag : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_zero == ($past(in_data) == '0)));

   // R5: strobe latency of one clock
   a_r5_valid_rise : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r5_valid_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R6: results hold through idle clocks
   a_r6_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_char) && $stable(out_frac) && $stable(out_zero)));

endmodule

// File: tb/log2_approx_tb_top.sv
`timescale 1ns/1ps
module log2_approx_tb_top;
   import lg2c_pkg::*;

   localparam time CLK_P = 20ns;
   localparam int  WA = 16;
   localparam int  WB = 5;
   localparam int  CA = 4;
   localparam int  CB = 3;

   typedef struct {
      bit      v;
      int      c;
      longint  f;
      bit      z;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [WA-1:0] da = '0;
   logic [WB-1:0] db = '0;

   logic          va, vb, za, zb;
   logic [CA-1:0] ca;
   logic [CB-1:0] cb;
   logic [WA-1:0] fa;
   logic [WB-1:0] fb;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   exp_t qa[$];
   exp_t qb[$];
   exp_t la, lb;

   always #(CLK_P/2) clk = ~clk;

   log2_approx #(.DATA_W(WA), .LOD_STYLE(LOD_TREE)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(da),
      .out_valid(va), .out_char(ca), .out_frac(fa), .out_zero(za));

   log2_approx #(.DATA_W(WB), .LOD_STYLE(LOD_SCAN)) dut_n5_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(db),
      .out_valid(vb), .out_char(cb), .out_frac(fb), .out_zero(zb));

   function automatic exp_t model(input longint x, input int n, input bit v);
      exp_t e;
      int msb;
      e.v = v;
      if (x == 0) begin
         e.c = 0; e.f = 0; e.z = 1;
      end else begin
         msb = 0;
         for (int i = 0; i < n; i++) if (x[i]) msb = i;
         e.c = msb;
         e.f = ((x - (longint'(1) << msb)) << (n - msb)) & ((longint'(1) << n) - 1);
         e.z = 0;
      end
      return e;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [WA-1:0] a, input logic [WB-1:0] b);
      exp_t ea, eb;
      string ta_c, ta_f, ta_z;
      in_valid = v; da = a; db = b;
      if (v) begin
         ea = model(longint'(a), WA, 1'b1);
         eb = model(longint'(b), WB, 1'b1);
      end else begin
         ea = la; ea.v = 1'b0;
         eb = lb; eb.v = 1'b0;
      end
      qa.push_back(ea); qb.push_back(eb);
      la = ea; lb = eb;
      @(posedge clk);
      @(negedge clk);
      ea = qa.pop_front();
      eb = qb.pop_front();
      if (!v) begin
         ta_c = "R6"; ta_f = "R6"; ta_z = "R6";
      end else if (a == '0) begin
         ta_c = "R3"; ta_f = "R3"; ta_z = "R3";
      end else begin
         ta_c = "R1"; ta_f = "R2"; ta_z = "R4";
      end
      chk(va == ea.v, "R5", "valid16", va, ea.v);
      chk(ca == ea.c, ta_c, "char16", ca, ea.c);
      chk(fa == ea.f, ta_f, "frac16", fa, ea.f);
      chk(za == ea.z, ta_z, "zero16", za, ea.z);
      chk(vb == eb.v, "R9", "valid5", vb, eb.v);
      chk(cb == eb.c, "R9", "char5", cb, eb.c);
      chk(fb == eb.f, "R9", "frac5", fb, eb.f);
      chk(zb == eb.z, "R9", "zero5", zb, eb.z);
   endtask

   initial begin
      logic [15:0] lfsr;
      int k;
      la = '{v:0, c:0, f:0, z:0};
      lb = '{v:0, c:0, f:0, z:0};
      repeat (3) @(negedge clk);
      // R7: reset state
      chk(va == 0 && ca == 0 && fa == 0 && za == 0, "R7", "reset16",
          {va, ca, fa, za}, 0);
      chk(vb == 0 && cb == 0 && fb == 0 && zb == 0, "R7", "reset5",
          {vb, cb, fb, zb}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      k = 0;

      step(1, 16'h6735, 5'(k)); k++;
      // R8: worked example
      chk(ca == 4'd14, "R8", "example char", ca, 14);
      chk(fa == 16'h9CD4, "R8", "example frac", fa, 16'h9CD4);

      step(1, 16'h0000, 5'(k)); k++;
      step(0, 16'hFFFF, 5'(k)); k++;
      step(0, 16'h1234, 5'(k)); k++;
      step(1, 16'h0001, 5'(k)); k++;
      step(1, 16'h8000, 5'(k)); k++;
      step(1, 16'hFFFF, 5'(k)); k++;
      step(0, 16'h0000, 5'(k)); k++;
      for (int i = 0; i < WA; i++) begin
         step(1, 16'(1) << i, 5'(k)); k++;
      end
      lfsr = 16'hACE1;
      for (int i = 0; i < 48; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step((i % 5) != 3, lfsr >> (i % 16), 5'(k)); k++;
      end
      for (int i = 0; i < 32; i++) begin
         step(1, 16'(i * 977), 5'(i));
      end
      step(0, 16'h0000, 5'd0);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule